// File: doc/BRIEF.md
# Free-Running Cycle Interrupt Timer

This block counts CPU clock cycles in a 15-bit up-counter and pulls an active-low interrupt line once the count arrives at its all-ones terminal value. Software programs the timer by writing the live count itself, split across two byte-wide registers. There is no separate reload value, so the value read back is always the current count, and it may be read or rewritten while the timer runs.

Each rising edge of `clk` is one CPU cycle. With `cpu_rnw` low, that cycle is a write of `cpu_wdata` to the register selected by `cpu_addr`. Read data is combinational from the selected register. When the counter reaches 0x7FFF by counting, it latches a pending flag and stops advancing. The interrupt is held until software writes either count register. The asynchronous reset is released to the logic through a two-stage synchronizer.

Top module: `cyc_irq_timer`

## Requirements
- R1: Addresses whose bits 15:11 equal 5'b01010 (0x5000-0x57FF) form the low count register. Writing it sets count bits 7:0, and reading it returns count bits 7:0.
- R2: Addresses whose bits 15:11 equal 5'b01011 (0x5800-0x5FFF) form the high register. Data bits 6:0 map to count bits 14:8 and data bit 7 is the run/interrupt enable, for both read and write.
- R3: While the enable is 1 and the count is below 0x7FFF, the count rises by exactly one per clock. While the enable is 0, the count holds.
- R4: When counting brings the count to 0x7FFF, an interrupt becomes pending on that same edge. The count then stays at 0x7FFF until it is written.
- R5: `irq_n` is 0 exactly when an interrupt is pending and the enable is 1. When loaded with 0x7FFF-N and enabled, `irq_n` falls on the Nth clock edge after the load.
- R6: Any write to the low or the high register clears a pending interrupt, so `irq_n` returns to 1 after that edge.
- R7: A write that lands in the same cycle as an increment replaces only the written byte. The other byte takes its incremented value.
- R8: While `rst_n` is 0, the count, the enable and the pending flag are 0, `irq_n` is 1 and reads return 0. The logic leaves reset on the second clock edge after `rst_n` rises.
- R9: Accesses outside both register spans change nothing. They do not clear a pending interrupt, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock, one count per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rnw | input | 1 | 1 = read, 0 = write this cycle |
| rd_data | output | 8 | Read data of the selected register, 0 elsewhere |
| irq_n | output | 1 | Active-low interrupt request, level-held |

## Verification
The count is visible through both registers, so a stuck or double-stepping counter appears in the first readback after a known number of cycles. A wrong terminal compare or a missing pending flag moves the falling edge of `irq_n` away from the exact Nth cycle after a load. The bench measures that edge cycle by cycle at values of N that do and do not cross the low-byte boundary. A pending flag that survives a write, or is cleared by a stray access, appears on `irq_n` one cycle after the write.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_LO   = 2'd1,
    RSEL_HI   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/cyc_rst_sync.sv
module cyc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/cyc_addr_decode.sv
module cyc_addr_decode
  import cyc_timer_pkg::*;
#(
  parameter int          PAGE_W  = 5,
  parameter logic [4:0]  LO_PAGE = 5'b01010,
  parameter logic [4:0]  HI_PAGE = 5'b01011
) (
  input  logic [PAGE_W-1:0] page,
  output reg_sel_e          sel
);
  always_comb begin
    if (page == LO_PAGE[PAGE_W-1:0])      sel = RSEL_LO;
    else if (page == HI_PAGE[PAGE_W-1:0]) sel = RSEL_HI;
    else                                  sel = RSEL_NONE;
  end
endmodule

// File: rtl/cyc_count_core.sv
module cyc_count_core
  import cyc_timer_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int LO_W   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_sel_e          sel,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              en_q,
  output logic              pend_q
);
  localparam int               HI_W     = CNT_W - LO_W;
  localparam int               EN_BIT   = DATA_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_PRE  = CNT_MAX - CNT_ONE;

  logic [CNT_W-1:0] cnt_d;
  logic             en_d;
  logic             pend_d;
  logic             step_ok;
  logic             wr_lo;
  logic             wr_hi;

  always_comb begin
    wr_lo   = wr && (sel == RSEL_LO);
    wr_hi   = wr && (sel == RSEL_HI);
    step_ok = en_q && (cnt_q != CNT_MAX);

    cnt_d = step_ok ? (cnt_q + CNT_ONE) : cnt_q;
    if (wr_lo) cnt_d[LO_W-1:0]     = wdata[LO_W-1:0];
    if (wr_hi) cnt_d[CNT_W-1:LO_W] = wdata[HI_W-1:0];

    en_d = wr_hi ? wdata[EN_BIT] : en_q;

    if (wr_lo || wr_hi) pend_d = 1'b0;
    else                pend_d = pend_q || (step_ok && (cnt_q == CNT_PRE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cyc_timer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 15,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rnw,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_n
);
  localparam int LO_W = DATA_W;
  localparam int HI_W = CNT_W - LO_W;

  logic             rst_sync_n;
  reg_sel_e         reg_sel;
  logic [CNT_W-1:0] cnt_w;
  logic             en_w;
  logic             pend_w;
  logic             unused_addr_low;

  assign unused_addr_low = ^cpu_addr[ADDR_W-PAGE_W-1:0];

  cyc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  cyc_addr_decode #(.PAGE_W(PAGE_W)) u_dec (
    .page (cpu_addr[ADDR_W-1 -: PAGE_W]),
    .sel  (reg_sel)
  );

  cyc_count_core #(.CNT_W(CNT_W), .LO_W(LO_W), .DATA_W(DATA_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sel    (reg_sel),
    .wr     (!cpu_rnw),
    .wdata  (cpu_wdata),
    .cnt_q  (cnt_w),
    .en_q   (en_w),
    .pend_q (pend_w)
  );

  always_comb begin
    rd_data = '0;
    case (reg_sel)
      RSEL_LO: rd_data = cnt_w[LO_W-1:0];
      RSEL_HI: begin
        rd_data[HI_W-1:0] = cnt_w[CNT_W-1:LO_W];
        rd_data[DATA_W-1] = en_w;
      end
      default: rd_data = '0;
    endcase
  end

  assign irq_n = !(pend_w && en_w);
endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk
  import cyc_timer_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_sync_n,
  input reg_sel_e         reg_sel,
  input logic             cpu_rnw,
  input logic             irq_n,
  input logic [CNT_W-1:0] cnt_w,
  input logic             en_w,
  input logic             pend_w
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic reg_wr;
  assign reg_wr = !cpu_rnw && (reg_sel != RSEL_NONE);

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en_w && cnt_w != CNT_MAX && !reg_wr) |=> (cnt_w == $past(cnt_w) + CNT_ONE));

  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!en_w && !reg_wr) |=> $stable(cnt_w));

  assert_hold_at_max_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt_w == CNT_MAX && !reg_wr) |=> (cnt_w == CNT_MAX));

  assert_pend_at_max_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(pend_w) |-> (cnt_w == CNT_MAX));

  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !irq_n |-> (en_w && pend_w));

  assert_ack_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_wr |=> irq_n);

  assert_stray_keeps_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_sel == RSEL_NONE && !irq_n) |=> !irq_n);
endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .reg_sel    (reg_sel),
  .cpu_rnw    (cpu_rnw),
  .irq_n      (irq_n),
  .cnt_w      (cnt_w),
  .en_w       (en_w),
  .pend_w     (pend_w)
);

// File: tb/sim_cyc_irq_timer.sv
`timescale 1ns/100ps
module sim_cyc_irq_timer;
  localparam int MAXV = 32'h7FFF;

  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_rnw;
  logic [7:0]  rd_data;
  logic        irq_n;

  int n_cmp;
  int n_bad;
  bit done;

  cyc_irq_timer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rnw   (cpu_rnw),
    .rd_data   (rd_data),
    .irq_n     (irq_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_rnw   = 1'b0;
    @(negedge clk);
    cpu_rnw   = 1'b1;
    cpu_addr  = 16'h0000;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    cpu_addr = a;
    #0.4;
    d = rd_data;
    cpu_addr = 16'h0000;
  endtask

  task automatic load(input int v, input logic en);
    wr(16'h57FF, v[7:0]);
    wr(16'h5800, {en, v[14:8]});
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state;
    logic [7:0] d;
    rd(16'h5000, d); chk("R8 reset low", d, 0);
    rd(16'h5FFF, d); chk("R8 reset high", d, 0);
    chk("R8 reset irq_n", irq_n, 1);
  endtask

  task automatic t_disabled_hold;
    logic [7:0] d;
    load(32'h1234, 1'b0);
    repeat (10) @(negedge clk);
    rd(16'h5000, d); chk("R1 low readback, R3 hold", d, 8'h34);
    rd(16'h5FFF, d); chk("R2 high readback, R3 hold", d, 8'h12);
  endtask

  task automatic t_counting;
    logic [7:0] d;
    load(32'h0100, 1'b1);
    repeat (10) @(negedge clk);
    rd(16'h5000, d); chk("R3 low after 10", d, 8'h0A);
    rd(16'h5FFF, d); chk("R3 R2 high after 10", d, 8'h81);
    wr(16'h5800, 8'h00);
  endtask

  task automatic t_irq_after(input int n);
    int fails;
    fails = 0;
    load(MAXV - n, 1'b1);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i < n && irq_n !== 1'b1) fails++;
    end
    chk("R5 no early irq", fails, 0);
    chk("R4 R5 irq at cycle N", irq_n, 0);
  endtask

  task automatic t_hold_and_ack_lo;
    logic [7:0] d;
    t_irq_after(5);
    repeat (4) @(negedge clk);
    rd(16'h5000, d); chk("R4 held low", d, 8'hFF);
    rd(16'h5FFF, d); chk("R4 held high", d, 8'hFF);
    chk("R5 irq still held", irq_n, 0);
    wr(16'h5000, 8'h00);
    chk("R6 ack by low write", irq_n, 1);
    wr(16'h5800, 8'h00);
  endtask

  task automatic t_ack_hi;
    t_irq_after(1);
    wr(16'h5FFF, 8'h90);
    chk("R6 ack by high write", irq_n, 1);
    wr(16'h5800, 8'h00);
  endtask

  task automatic t_write_priority;
    logic [7:0] d;
    wr(16'h5000, 8'hFE);
    wr(16'h5800, 8'h80);
    wr(16'h5000, 8'h10);
    rd(16'h5000, d); chk("R7 low written over step", d, 8'h10);
    rd(16'h5FFF, d); chk("R7 high untouched", d, 8'h80);
    wr(16'h5800, 8'h85);
    rd(16'h5000, d); chk("R7 low stepped", d, 8'h11);
    rd(16'h5FFF, d); chk("R7 high written", d, 8'h85);
    wr(16'h5800, 8'h00);
  endtask

  task automatic t_stray;
    logic [7:0] d;
    t_irq_after(2);
    wr(16'h6000, 8'h00);
    wr(16'h4FFF, 8'h00);
    chk("R9 stray writes keep irq", irq_n, 0);
    rd(16'h6000, d); chk("R9 stray read 6000", d, 0);
    rd(16'h4FFF, d); chk("R9 stray read 4FFF", d, 0);
    rd(16'h5000, d); chk("R9 count untouched", d, 8'hFF);
  endtask

  task automatic t_reset_midrun;
    logic [7:0] d;
    rst_n = 1'b0;
    #0.5;
    chk("R8 async irq_n", irq_n, 1);
    rd(16'h5FFF, d); chk("R8 async high clear", d, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(16'h5000, d); chk("R8 low after reset", d, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    done = 1'b0;
    cpu_addr = 16'h0000;
    cpu_wdata = 8'h00;
    cpu_rnw = 1'b1;
    @(negedge clk);
    do_reset();
    t_reset_state();
    t_disabled_hold();
    t_counting();
    t_irq_after(5);
    wr(16'h5800, 8'h00);
    t_irq_after(300);
    wr(16'h5800, 8'h00);
    t_hold_and_ack_lo();
    t_ack_hi();
    t_write_priority();
    t_stray();
    t_reset_midrun();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule